// File: doc/BRIEF.md
# SDRAM Refresh Command Sequencer

This block sits on the controller side of a synchronous DRAM. It issues auto-refresh commands and moves the device into and out of self-refresh. It drives the chip-select, row strobe, column strobe, write enable and clock-enable pins directly. It accepts three one-cycle request pulses: refresh, self-refresh enter and self-refresh exit. It also takes a level flag that says all banks are precharged and idle, and an acknowledge that says the memory clock is running.

The sequencer holds each request until the timing rules allow it to be issued. A refresh or self-refresh entry goes out only after the banks have been idle for `T_RP` cycles. It goes out only when the spacing window left by the previous refresh or self-refresh exit has closed. The `ready` output tells the rest of the controller when the next command it issues may legally reach the device. The surrounding controller is expected to close all banks before it raises the idle flag.

Top module: `sdram_refresh_seq`

## Requirements
- R1: Pin outputs. During reset the pins show deselect: `cs_n`, `ras_n`, `cas_n` and `we_n` are high, `cke` is high, and `ready` is high. Outside a command cycle and outside self-refresh, the pins show a NOP: `cs_n` low, `ras_n`/`cas_n`/`we_n` high, `cke` high.
- R2: Auto-refresh encoding and timing. An auto-refresh appears on the pins as `cs_n`, `ras_n` and `cas_n` low with `we_n` and `cke` high. It lasts exactly one cycle for each refresh request accepted. It appears no earlier than the cycle after the edge that sampled `ref_req`.
- R3: Idle precondition. An auto-refresh or self-refresh entry is issued at edge E only if `banks_idle` was sampled high on every edge from E−`T_RP` through E. Any low sample restarts this count.
- R4: Refresh spacing. After an auto-refresh in cycle C, no further refresh and no self-refresh entry appears before cycle C+`T_RC`. A refresh that is already waiting appears exactly at C+`T_RC`.
- R5: Self-refresh entry. Entry appears as `cs_n`, `ras_n`, `cas_n` and `cke` low with `we_n` high, for one cycle, in response to an `sr_enter` pulse. After that cycle the pins show deselect with `cke` low.
- R6: Hold in self-refresh. `cke` stays low for every cycle until the exit. No command is issued during self-refresh, and refresh requests that arrive then are held.
- R7: Exit handshake. An `sr_exit` pulse raises `cke` in the cycle after the first edge at which both the exit request (live or held) and `clk_ack` are seen. An exit request that arrives while `clk_ack` is low is held until then.
- R8: Exit spacing. After `cke` rises in cycle X, no command appears before cycle X+`T_RC`+`T_SREX`. A held refresh appears exactly then.
- R9: Ready output. `ready` is low while `cke` is low and while a spacing window is open. After an auto-refresh in cycle C, `ready` is low for cycles C through C+`T_RC`−2 and high in cycle C+`T_RC`−1.
- R10: Priority. When a refresh and a self-refresh entry are both waiting, the auto-refresh goes first. The entry follows `T_RC` cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_req | input | 1 | One-cycle pulse requesting an auto-refresh |
| sr_enter | input | 1 | One-cycle pulse requesting self-refresh entry |
| sr_exit | input | 1 | One-cycle pulse requesting self-refresh exit |
| clk_ack | input | 1 | High when the memory clock is running again |
| banks_idle | input | 1 | High while all banks are precharged and idle |
| cke | output | 1 | Clock enable pin |
| cs_n | output | 1 | Chip select pin, active low |
| ras_n | output | 1 | Row strobe pin, active low |
| cas_n | output | 1 | Column strobe pin, active low |
| we_n | output | 1 | Write enable pin, active low |
| ready | output | 1 | High when a command issued on the next edge is legal |

## Verification
The bench sweeps the arrival time of a refresh request across the point where the idle count reaches `T_RP`. A design that counts one edge short issues the refresh a cycle early, and one that keeps counting across a dropped idle flag issues it too soon after the drop. Back-to-back refreshes are swept over every request spacing up to `T_RC`+1. This catches an off-by-one in the spacing window and in the `ready` edge. Self-refresh is exercised with the clock acknowledge arriving zero to three cycles after the exit request. A design that drops the held exit, or raises `cke` without the acknowledge, is caught there, as is a refresh held across self-refresh that is released before `T_RC`+`T_SREX`.

// File: rtl/sdram_refresh_seq.sv
module sdram_refresh_seq #(
  parameter int unsigned T_RP   = 2,
  parameter int unsigned T_RC   = 7,
  parameter int unsigned T_SREX = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_req,
  input  logic sr_enter,
  input  logic sr_exit,
  input  logic clk_ack,
  input  logic banks_idle,
  output logic cke,
  output logic cs_n,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic ready
);
  localparam int unsigned GAP_MAX = T_RC + T_SREX;
  localparam int unsigned CW = $clog2(GAP_MAX + 1);
  localparam int unsigned IW = $clog2(T_RP + 1);

  logic [CW-1:0] gap_q;
  logic [IW-1:0] idle_q;
  logic ref_pend_q, sre_pend_q, srx_pend_q, in_sr_q;
  logic idle_ok, can_issue, do_ar, do_sre, do_srx;

  assign idle_ok   = banks_idle && (idle_q >= IW'(T_RP));
  assign can_issue = !in_sr_q && (gap_q == '0) && idle_ok;
  assign do_ar     = can_issue && ref_pend_q;
  assign do_sre    = can_issue && !ref_pend_q && sre_pend_q;
  assign do_srx    = in_sr_q && (sr_exit || srx_pend_q) && clk_ack;
  assign ready     = !in_sr_q && cke && (gap_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_q     <= '0;
      gap_q      <= '0;
      ref_pend_q <= 1'b0;
      sre_pend_q <= 1'b0;
      srx_pend_q <= 1'b0;
      in_sr_q    <= 1'b0;
    end else begin
      if (!banks_idle)               idle_q <= '0;
      else if (idle_q != IW'(T_RP))  idle_q <= idle_q + 1'b1;

      ref_pend_q <= (ref_pend_q && !do_ar) || ref_req;
      sre_pend_q <= (sre_pend_q && !do_sre) ||
                    (sr_enter && !in_sr_q && !do_sre);
      srx_pend_q <= in_sr_q && !do_srx && (srx_pend_q || sr_exit);

      if (do_sre)      in_sr_q <= 1'b1;
      else if (do_srx) in_sr_q <= 1'b0;

      if (do_ar)               gap_q <= CW'(T_RC - 1);
      else if (do_srx)         gap_q <= CW'(GAP_MAX - 1);
      else if (gap_q != '0)    gap_q <= gap_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {cs_n, ras_n, cas_n, we_n} <= 4'b1111;
      cke <= 1'b1;
    end else if (do_ar) begin
      {cs_n, ras_n, cas_n, we_n} <= 4'b0001;
      cke <= 1'b1;
    end else if (do_sre) begin
      {cs_n, ras_n, cas_n, we_n} <= 4'b0001;
      cke <= 1'b0;
    end else if (in_sr_q && !do_srx) begin
      {cs_n, ras_n, cas_n, we_n} <= 4'b1111;
      cke <= 1'b0;
    end else begin
      {cs_n, ras_n, cas_n, we_n} <= 4'b0111;
      cke <= 1'b1;
    end
  end
endmodule

module sdram_refresh_seq_chk #(
  parameter int unsigned T_RP   = 2,
  parameter int unsigned T_RC   = 7,
  parameter int unsigned T_SREX = 1
) (
  input logic clk,
  input logic rst_n,
  input logic clk_ack,
  input logic banks_idle,
  input logic cke,
  input logic cs_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic ready
);
  localparam int unsigned WW = $clog2(T_RC + T_SREX + 1);

  logic [WW-1:0] win_q;
  logic prev_cke_q;
  logic is_ar, is_cmd;

  assign is_ar  = cke && !cs_n && !ras_n && !cas_n && we_n;
  assign is_cmd = !cs_n && !(ras_n && cas_n && we_n);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q      <= '0;
      prev_cke_q <= 1'b1;
    end else begin
      prev_cke_q <= cke;
      if (is_ar)                   win_q <= WW'(T_RC - 1);
      else if (cke && !prev_cke_q) win_q <= WW'(T_RC + T_SREX - 1);
      else if (win_q != '0)        win_q <= win_q - 1'b1;
    end
  end

  a_r3_idle_before_refresh: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cmd && prev_cke_q) |-> $past(banks_idle));

  a_r4_r8_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmd |-> (win_q == '0));

  a_r5_entry_encoding: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> (!cs_n && !ras_n && !cas_n && we_n));

  a_r6_deselect_in_sr: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke && !prev_cke_q) |-> cs_n);

  a_r7_exit_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> $past(clk_ack));

  a_r9_ready_low_in_sr: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> !ready);
endmodule

bind sdram_refresh_seq sdram_refresh_seq_chk #(
  .T_RP(T_RP), .T_RC(T_RC), .T_SREX(T_SREX)
) chk_i (
  .clk(clk), .rst_n(rst_n), .clk_ack(clk_ack), .banks_idle(banks_idle),
  .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .ready(ready)
);

// File: tb/sdram_refresh_seq_tb.sv
`timescale 1ns/1ps
module sdram_refresh_seq_tb_top;
  localparam int T_RP = 3, T_RC = 5, T_SREX = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_req = 1'b0, sr_enter = 1'b0, sr_exit = 1'b0;
  logic clk_ack = 1'b1, banks_idle = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n, ready;

  int cyc = 0, n_chk = 0, n_fail = 0, bad_enc = 0;

  always #2.5 clk = ~clk;

  sdram_refresh_seq #(.T_RP(T_RP), .T_RC(T_RC), .T_SREX(T_SREX)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_req(ref_req), .sr_enter(sr_enter),
    .sr_exit(sr_exit), .clk_ack(clk_ack), .banks_idle(banks_idle),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ready(ready)
  );

  function automatic bit is_ar();  return cke && !cs_n && !ras_n && !cas_n && we_n; endfunction
  function automatic bit is_sre(); return !cke && !cs_n && !ras_n && !cas_n && we_n; endfunction
  function automatic bit is_nop(); return cke && !cs_n && ras_n && cas_n && we_n; endfunction
  function automatic int imax(int a, int b); return (a > b) ? a : b; endfunction

  task automatic tick();
    @(posedge clk);
    cyc++;
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle(input bit idle, input int n);
    ref_req = 0; sr_enter = 0; sr_exit = 0; clk_ack = 1; banks_idle = idle;
    repeat (n) tick();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (3) tick();
    // R1 reset state
    chk(cs_n && ras_n && cas_n && we_n, "R1 reset deselect", {cs_n, ras_n, cas_n, we_n}, 15);
    chk(cke === 1'b1, "R1 reset cke", cke, 1);
    chk(ready === 1'b1, "R1 reset ready", ready, 1);
    rst_n = 1;
    tick();
    chk(is_nop(), "R1 NOP after reset", {cke, cs_n, ras_n, cas_n, we_n}, 23);

    // R2 R3: refresh request swept around the idle threshold
    for (int off = -2; off <= 5; off++) begin
      int base, s, r, got, extra, exp;
      settle(0, T_RC + 2);
      base = cyc; s = base + 3; r = base + 3 + off; got = -1; extra = 0;
      for (int k = 1; k <= T_RP + 14; k++) begin
        banks_idle = (base + k >= s);
        ref_req = (base + k == r);
        tick();
        if (is_ar()) begin
          if (got < 0) got = cyc; else extra++;
        end else if (!is_nop()) bad_enc++;
      end
      ref_req = 0;
      exp = imax(s + T_RP, r + 1);
      chk(got == exp, "R3 refresh after idle time", got - base, exp - base);
      chk(extra == 0, "R2 one refresh per request", extra, 0);
    end

    // R3: idle drop restarts the count
    begin
      int base, d, got;
      settle(0, T_RC + 2);
      base = cyc; got = -1;
      d = base + 1 + T_RP - 1;
      for (int k = 1; k <= 3 * T_RP + 6; k++) begin
        banks_idle = (base + k != d);
        ref_req = (k == 1);
        tick();
        if (is_ar() && got < 0) got = cyc;
      end
      chk(got == d + 1 + T_RP, "R3 idle drop restarts", got - base, d + 1 + T_RP - base);
    end

    // R4 R9: back-to-back refreshes over all spacings
    for (int dd = 1; dd <= T_RC + 1; dd++) begin
      int base, e1, g1, g2, rbad, exp2;
      settle(1, T_RP + T_RC + 2);
      base = cyc; e1 = base + 2; g1 = -1; g2 = -1; rbad = 0;
      for (int k = 1; k <= 3 * T_RC + 6; k++) begin
        ref_req = (base + k == base + 1) || (base + k == e1 + dd);
        tick();
        if (is_ar()) begin
          if (g1 < 0) g1 = cyc; else if (g2 < 0) g2 = cyc;
        end else if (!is_nop()) bad_enc++;
        if (cyc >= e1 && cyc <= e1 + T_RC - 2 && ready) rbad++;
        if (cyc == e1 + T_RC - 1 && !ready) rbad++;
      end
      ref_req = 0;
      exp2 = imax(e1 + T_RC, e1 + dd + 1);
      chk(g1 == e1, "R2 refresh cycle", g1 - base, e1 - base);
      chk(g2 == exp2, "R4 refresh spacing", g2 - base, exp2 - base);
      chk(rbad == 0, "R9 ready window", rbad, 0);
    end

    // R5 R6 R7 R8: self-refresh with delayed clock acknowledge
    for (int ad = 0; ad <= 3; ad++) begin
      int base, e, x, xe, got_ar, sre_ok, hold_bad, early;
      settle(1, T_RP + T_RC + 2);
      base = cyc; e = base + 2; x = e + 4; xe = x + ad;
      got_ar = -1; sre_ok = 0; hold_bad = 0; early = 0;
      for (int k = 1; k <= 4 * T_RC + 10; k++) begin
        sr_enter = (base + k == base + 1);
        ref_req  = (base + k == e + 2);
        sr_exit  = (base + k == x);
        clk_ack  = (ad == 0) || (base + k < e + 1) || (base + k >= xe);
        tick();
        if (cyc == e && is_sre()) sre_ok = 1;
        if (cyc > e && cyc < xe && (cke || !cs_n || ready)) hold_bad++;
        if (cyc == xe && !cke) hold_bad++;
        if (is_ar() && got_ar < 0) got_ar = cyc;
        if (cyc > e && cyc < xe + T_RC + T_SREX && !cs_n && !is_nop()) early++;
      end
      sr_enter = 0; ref_req = 0; sr_exit = 0; clk_ack = 1;
      chk(sre_ok == 1, "R5 entry encoding", sre_ok, 1);
      chk(hold_bad == 0, "R6 R7 hold and exit", hold_bad, 0);
      chk(early == 0, "R8 no command in exit window", early, 0);
      chk(got_ar == xe + T_RC + T_SREX, "R8 held refresh after exit",
          got_ar - base, xe + T_RC + T_SREX - base);
    end

    // R10: refresh before entry
    begin
      int base, g_ar, g_sre;
      settle(1, T_RP + T_RC + 2);
      base = cyc; g_ar = -1; g_sre = -1;
      for (int k = 1; k <= 3 * T_RC; k++) begin
        ref_req = (k == 1); sr_enter = (k == 1);
        tick();
        if (is_ar() && g_ar < 0) g_ar = cyc;
        if (is_sre() && g_sre < 0) g_sre = cyc;
      end
      ref_req = 0; sr_enter = 0;
      chk(g_ar == base + 2, "R10 refresh first", g_ar - base, 2);
      chk(g_sre == base + 2 + T_RC, "R10 entry after spacing", g_sre - base, 2 + T_RC);
      sr_exit = 1; tick(); sr_exit = 0; tick();
      chk(cke === 1'b1, "R7 exit with ack", cke, 1);
      repeat (T_RC + T_SREX) tick();
    end

    chk(bad_enc == 0, "R1 NOP between commands", bad_enc, 0);
    summary();
    $finish;
  end
endmodule